// File: doc/BRIEF.md
# Four-Level Decision-Feedback Slicer with Burst-Tail Flags

This block equalizes a stream of four-level line symbols with a single feedback tap and decides each symbol. On every accepted sample it takes a signed fixed-point input. It subtracts the run-time tap weight times the level of the symbol it decided last, and slices the difference to a 2-bit symbol in the range 0..3. Symbol levels are the integers 0, 1, 2 and 3 in sample units.

A single tap can spread one wrong decision into a run of errors that alternate +1/−1. Such a run stops on the sample whose equalized value lands clearly outside the span of the outer levels. The block watches for that event with two comparators. One checks above the top level and one checks below the bottom level. Each comparator uses a guard band equal to the margin input scaled by the magnitude of the tap weight. Their OR is a burst-tail flag, which a downstream precoding decoder can use to repair the last symbol of the run. All outputs are registered and appear one clock after the input strobe.

Top module: `dfe_burst_end_top`

## Requirements
- R1: The equalized value is sampleIn minus weightIn times L. L is the integer level (0..3) of the previous decided symbol, not the previous equalized value. Samples and weight are two's complement with FRAC_W fraction bits. The product is exact. With weight 1.0, a sample of 4.0 after a decision of 1 gives 3.0.
- R2: The decided symbol is the number of thresholds 0.5, 1.5 and 2.5 that the equalized value reaches or exceeds. A value exactly on a threshold takes the upper symbol. Values above 2.5 clamp to 3, and values below 0.5 clamp to 0.
- R3: overflowOut is 1 exactly when the equalized value is strictly greater than 3.0 plus the effective margin.
- R4: underflowOut is 1 exactly when the equalized value is strictly less than minus the effective margin.
- R5: The effective margin is marginIn (unsigned, FRAC_W fraction bits) times the magnitude of weightIn, rounded toward zero to FRAC_W fraction bits. A margin of zero makes both comparisons strict against 0.0 and 3.0.
- R6: burstEndOut is the OR of overflowOut and underflowOut. Overflow and underflow are never both 1.
- R7: A sample accepted with validIn high at a clock edge produces its outputs at that edge, with validOut high for one cycle. validOut is low after any edge where validIn was low.
- R8: An edge with validIn low changes no state. The symbol and flag outputs hold their values, and the next accepted sample still uses the last decided symbol as feedback.
- R9: Reset (rstN low) clears validOut, the symbol and all flags, and sets the feedback symbol to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Sample strobe |
| sampleIn | input | SAMPLE_W | Signed received sample, FRAC_W fraction bits |
| weightIn | input | WEIGHT_W | Signed tap weight, FRAC_W fraction bits |
| marginIn | input | MARGIN_W | Unsigned guard band, FRAC_W fraction bits |
| validOut | output | 1 | Outputs updated this cycle |
| symOut | output | 2 | Decided symbol 0..3 |
| overflowOut | output | 1 | Equalized value above the top guard bound |
| underflowOut | output | 1 | Equalized value below the bottom guard bound |
| burstEndOut | output | 1 | Burst-tail flag (overflow OR underflow) |

## Verification
The bench builds the block with SAMPLE_W=8, FRAC_W=2, WEIGHT_W=5 and MARGIN_W=3. That makes every sample code, every weight code from −4.0 to +3.75, and every margin code reachable in one sweep. Because the feedback symbol carries across the sweep, the tie points on each threshold and the comparison bounds are each met under all four previous levels, including negative weights and weight 1.0. Idle cycles are scattered through the sweep to show that gaps in the strobe leave the output and the feedback untouched.

// File: rtl/dfe_burst_pkg.sv
package dfe_burst_pkg;
  localparam int unsigned NUM_SYMBOLS = 4;
  localparam int unsigned SYM_W = 2;

  typedef struct packed {
    logic capture;   // accept the current sample and update all state
  } dfeStrobes_t;
endpackage

// File: rtl/dfe_ctrl.sv
module dfe_ctrl
  import dfe_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  output dfeStrobes_t strobes,
  output logic        validOut
);
  always_comb begin
    strobes.capture = validIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end
endmodule

// File: rtl/dfe_datapath.sv
module dfe_datapath
  import dfe_burst_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned FRAC_W   = 4,
  parameter int unsigned WEIGHT_W = 8,
  parameter int unsigned MARGIN_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dfeStrobes_t                strobes,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic signed [WEIGHT_W-1:0] weightIn,
  input  logic        [MARGIN_W-1:0] marginIn,
  output logic        [SYM_W-1:0]    symOut,
  output logic                       overflowOut,
  output logic                       underflowOut,
  output logic                       burstEndOut
);
  localparam int unsigned PROD_W = WEIGHT_W + 3;
  localparam int unsigned MPROD_W = MARGIN_W + WEIGHT_W;
  localparam int unsigned BASE_W = (SAMPLE_W > PROD_W) ? SAMPLE_W : PROD_W;
  localparam int unsigned WIDE_W = (BASE_W > MPROD_W) ? BASE_W : MPROD_W;
  localparam int unsigned CMP_W  = ((WIDE_W > FRAC_W + 3) ? WIDE_W : FRAC_W + 3) + 2;
  localparam logic signed [CMP_W-1:0] TOP_LVL = CMP_W'((NUM_SYMBOLS - 1) << FRAC_W);

  // feedback: previous decision is the registered symbol
  logic signed [2:0]        prevLvl;
  logic signed [PROD_W-1:0] fbProd;
  logic signed [CMP_W-1:0]  eqVal;

  assign prevLvl = $signed({1'b0, symOut});
  assign fbProd  = PROD_W'(weightIn) * PROD_W'(prevLvl);
  assign eqVal   = CMP_W'(sampleIn) - CMP_W'(fbProd);

  // slicer: thermometer of half-integer thresholds
  logic [NUM_SYMBOLS-2:0] above;
  for (genvar k = 0; k < NUM_SYMBOLS - 1; k++) begin : gThr
    localparam logic signed [CMP_W-1:0] THR = CMP_W'((2 * k + 1) << (FRAC_W - 1));
    assign above[k] = (eqVal >= THR);
  end

  logic [SYM_W-1:0] nextSym;
  always_comb begin
    nextSym = '0;
    for (int k = 0; k < NUM_SYMBOLS - 1; k++) begin
      nextSym = nextSym + SYM_W'(above[k]);
    end
  end

  // guard band scaled by weight magnitude, truncated toward zero
  logic [WEIGHT_W-1:0]     absWeight;
  logic [MPROD_W-1:0]      marginProd;
  logic [MPROD_W-1:0]      effMargin;
  logic signed [CMP_W-1:0] effMarginS;
  logic signed [CMP_W-1:0] topBound;
  logic signed [CMP_W-1:0] botBound;
  logic                    overNext;
  logic                    underNext;

  assign absWeight  = weightIn[WEIGHT_W-1] ? $unsigned(-weightIn) : $unsigned(weightIn);
  assign marginProd = MPROD_W'(marginIn) * MPROD_W'(absWeight);
  assign effMargin  = marginProd >> FRAC_W;
  assign effMarginS = $signed(CMP_W'(effMargin));
  assign topBound   = TOP_LVL + effMarginS;
  assign botBound   = -effMarginS;
  assign overNext   = (eqVal > topBound);
  assign underNext  = (eqVal < botBound);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symOut       <= '0;
      overflowOut  <= 1'b0;
      underflowOut <= 1'b0;
      burstEndOut  <= 1'b0;
    end else if (strobes.capture) begin
      symOut       <= nextSym;
      overflowOut  <= overNext;
      underflowOut <= underNext;
      burstEndOut  <= overNext | underNext;
    end
  end
endmodule

// File: rtl/dfe_burst_end_top.sv
module dfe_burst_end_top
  import dfe_burst_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned FRAC_W   = 4,
  parameter int unsigned WEIGHT_W = 8,
  parameter int unsigned MARGIN_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic signed [WEIGHT_W-1:0] weightIn,
  input  logic        [MARGIN_W-1:0] marginIn,
  output logic                       validOut,
  output logic [1:0]                 symOut,
  output logic                       overflowOut,
  output logic                       underflowOut,
  output logic                       burstEndOut
);
  dfeStrobes_t strobes;

  dfe_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobes  (strobes),
    .validOut (validOut)
  );

  dfe_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .FRAC_W   (FRAC_W),
    .WEIGHT_W (WEIGHT_W),
    .MARGIN_W (MARGIN_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .sampleIn     (sampleIn),
    .weightIn     (weightIn),
    .marginIn     (marginIn),
    .symOut       (symOut),
    .overflowOut  (overflowOut),
    .underflowOut (underflowOut),
    .burstEndOut  (burstEndOut)
  );
endmodule

// File: rtl/dfe_burst_end_checker.sv
module dfe_burst_end_checker (
  input logic       clk,
  input logic       rstN,
  input logic       validIn,
  input logic       validOut,
  input logic [1:0] symOut,
  input logic       overflowOut,
  input logic       underflowOut,
  input logic       burstEndOut
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(symOut) && $stable(overflowOut) &&
                  $stable(underflowOut) && $stable(burstEndOut)));

  assert_overflow_top_symbol_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowOut |-> (symOut == 2'd3));

  assert_underflow_bottom_symbol_R4: assert property (@(posedge clk) disable iff (!rstN)
    underflowOut |-> (symOut == 2'd0));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(overflowOut && underflowOut));

  assert_burst_end_marks_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overflowOut || underflowOut) |-> burstEndOut);
endmodule

bind dfe_burst_end_top dfe_burst_end_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .validIn      (validIn),
  .validOut     (validOut),
  .symOut       (symOut),
  .overflowOut  (overflowOut),
  .underflowOut (underflowOut),
  .burstEndOut  (burstEndOut)
);

// File: tb/sim_dfe_burst_end_top.sv
`timescale 1ns/1ps
module sim_dfe_burst_end_top;
  localparam int SW = 8;
  localparam int FW = 2;
  localparam int WW = 5;
  localparam int MW = 3;
  localparam int SCALE = 1 << FW;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 validIn = 1'b0;
  logic signed [SW-1:0] sampleIn = '0;
  logic signed [WW-1:0] weightIn = '0;
  logic        [MW-1:0] marginIn = '0;
  logic                 validOut;
  logic [1:0]           symOut;
  logic                 overflowOut;
  logic                 underflowOut;
  logic                 burstEndOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dfe_burst_end_top #(.SAMPLE_W(SW), .FRAC_W(FW), .WEIGHT_W(WW), .MARGIN_W(MW)) u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sampleIn(sampleIn),
    .weightIn(weightIn), .marginIn(marginIn), .validOut(validOut),
    .symOut(symOut), .overflowOut(overflowOut), .underflowOut(underflowOut),
    .burstEndOut(burstEndOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model state
  int modelPrev = 0;
  int lastSym = 0, lastOvf = 0, lastUnf = 0;

  task automatic applyVector(input int s, input int w, input int m);
    int eq, sym, eff, aw, ovf, unf;
    validIn  = 1'b1;
    sampleIn = SW'(s);
    weightIn = WW'(w);
    marginIn = MW'(m);
    eq  = s - w * modelPrev;                          // R1
    sym = (2 * eq >= SCALE ? 1 : 0) + (2 * eq >= 3 * SCALE ? 1 : 0)
        + (2 * eq >= 5 * SCALE ? 1 : 0);              // R2
    aw  = (w < 0) ? -w : w;
    eff = (m * aw) / SCALE;                           // R5
    ovf = (eq > 3 * SCALE + eff) ? 1 : 0;             // R3
    unf = (eq < -eff) ? 1 : 0;                        // R4
    @(negedge clk);
    check("R1/R2 symbol", int'(symOut), sym);
    check("R3/R5 overflow", int'(overflowOut), ovf);
    check("R4/R5 underflow", int'(underflowOut), unf);
    check("R6 burst end", int'(burstEndOut), ovf | unf);
    check("R7 valid", int'(validOut), 1);
    modelPrev = sym;
    lastSym = sym; lastOvf = ovf; lastUnf = unf;
  endtask

  task automatic idleCycle(input int s, input int w, input int m);
    validIn  = 1'b0;
    sampleIn = SW'(s);
    weightIn = WW'(w);
    marginIn = MW'(m);
    @(negedge clk);
    check("R7 valid low", int'(validOut), 0);
    check("R8 symbol held", int'(symOut), lastSym);
    check("R8 overflow held", int'(overflowOut), lastOvf);
    check("R8 underflow held", int'(underflowOut), lastUnf);
    check("R8 burst end held", int'(burstEndOut), lastOvf | lastUnf);
  endtask

  initial begin
    int gap = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 validOut", int'(validOut), 0);
    check("R9 symbol", int'(symOut), 0);
    check("R9 overflow", int'(overflowOut), 0);
    check("R9 underflow", int'(underflowOut), 0);
    check("R9 burst end", int'(burstEndOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R9/R1: first decision uses feedback symbol 0; weight 1.0 directed cases
    applyVector(1 * SCALE, SCALE, 0);   // decision 1
    applyVector(4 * SCALE, SCALE, 0);   // R1: 4 - 1 = 3 -> symbol 3
    applyVector(2 * SCALE, SCALE, 0);   // 2 - 3 = -1 -> underflow, R4
    applyVector(5 * SCALE, SCALE, 1);   // 5 - 0 = 5 > 3.25 -> overflow, R3
    idleCycle(-100, -3, 7);             // R8
    applyVector(3 * SCALE, SCALE, 0);   // R8: feedback still 3 -> 0
    // exhaustive sweep
    for (int w = -(1 << (WW - 1)); w < (1 << (WW - 1)); w++) begin
      for (int m = 0; m < (1 << MW); m++) begin
        for (int s = -(1 << (SW - 1)); s < (1 << (SW - 1)); s++) begin
          applyVector(s, w, m);
          gap++;
          if (gap % 17 == 0) idleCycle(s ^ 8'h55, -w, m ^ 3);
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule